// File: doc/BRIEF.md
# Fault and Event Status Latch Register

This block gathers the fault and event conditions of a two-slot smart card front end into one 8-bit status byte that a host can read. It also drives a shared active-low interrupt line. Every condition input is an already-digitised level from the pins or the analog monitors. Each input passes through a synchroniser. After that, each status bit applies its own rule for setting and clearing. Level faults stay latched while their cause persists. Presence and auxiliary-pin bits record any edge. The supervisor bit will not clear while the alarm pulse is running.

The host raises `rd_stb` for one or more cycles. The byte on `rd_data` is the current latched state. The clears take effect on the edge that follows the end of the strobe. After each read, the host must wait until `rd_ready` returns high before it reads again or starts a card. The block also derives two kinds of control output from the synchronised conditions. The first is a driver enable that an over-temperature condition removes. The second is a per-card deactivation request that is raised by a short on that card's reset line.

Top module: `fault_event_latch`

## Requirements
- R1: After reset, `rd_data` reads 8'h10, so only the supervisor bit is set. `irq_n` is 0, `rd_ready` is 1, `drv_en` is 1 and both deactivation requests are 0. Bit 7 of `rd_data` always reads 0.
- R2: Card A's protection bit (bit 5) sets while `a_rst_short` or `a_pwr_short` is high. Card B's protection bit (bit 6) does the same for `b_rst_short` or `b_pwr_short`. A read clears a protection bit only if that card's short has gone by the time the read ends.
- R3: The thermal bit (bit 0) sets while `over_temp` is high, and a read clears it only if the flag has gone. `drv_en` is 0 while the synchronised `over_temp` is high.
- R4: The card A presence bit (bit 2) sets on any rising or falling edge of `a_present`. The card B presence bit (bit 3) does the same for `b_present`. Any read clears them.
- R5: The auxiliary bit (bit 1) sets on either edge of `aux_pin`. It stays set through any later edges on the pin until a read clears it.
- R6: The supervisor bit (bit 4) sets while `supply_fail` or `ext_hold` is high. A read that ends while the synchronised `alarm_pulse` is high leaves the bit set. A read that ends while it is low clears the bit.
- R7: `irq_n` is 0 exactly when any of bits 6, 5, 4, 3, 2 or 0 is set. Bit 1 also counts when the parameter `AUX_IN_IRQ` is 1, and is ignored when it is 0.
- R8: `a_deact_req` follows the synchronised `a_rst_short`, and `b_deact_req` follows the synchronised `b_rst_short`. A supply-line short alone raises no request.
- R9: When a bit's set condition and a read clear fall on the same clock edge, the bit stays set.
- R10: From the edge that ends a read, `rd_ready` is 0 for exactly `GAP_CYCLES` clock cycles and then returns to 1.
- R11: With the default two synchroniser stages, an input edge shows in the status byte after the third clock edge, and in `drv_en` and the deactivation requests after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_rst_short | input | 1 | Card A reset-line short flag |
| a_pwr_short | input | 1 | Card A supply-line short flag |
| b_rst_short | input | 1 | Card B reset-line short flag |
| b_pwr_short | input | 1 | Card B supply-line short flag |
| a_present | input | 1 | Card A presence pin level |
| b_present | input | 1 | Card B presence pin level |
| aux_pin | input | 1 | Auxiliary interrupt pin level |
| over_temp | input | 1 | Over-temperature flag |
| supply_fail | input | 1 | Supply below threshold flag |
| ext_hold | input | 1 | External reset-hold flag |
| alarm_pulse | input | 1 | Supervisor alarm pulse active |
| rd_stb | input | 1 | Host read strobe; clears apply after it ends |
| rd_data | output | 8 | Latched status byte |
| irq_n | output | 1 | Active-low interrupt |
| drv_en | output | 1 | Card driver enable, low during over-temperature |
| a_deact_req | output | 1 | Card A deactivation request |
| b_deact_req | output | 1 | Card B deactivation request |
| rd_ready | output | 1 | High once the post-read spacing has elapsed |

## Verification
A wrong clear rule shows at the port as a status bit that survives a read it should not survive, or one that vanishes while its cause is still present. This is visible on `rd_data` at the first sample after the strobe ends. A fault in the synchroniser or the edge detector moves the set by one cycle, or adds or loses a presence event. The cycle-exact latency checks catch this within three edges. A miscounting pacer shows as `rd_ready` returning one cycle early or late against the parameterised gap.

// File: rtl/fel_pkg.sv
package fel_pkg;
  localparam int STAT_W = 8;
  localparam int LATCH_W = 7;

  // status bit positions
  localparam int B_THERM  = 0;
  localparam int B_AUX    = 1;
  localparam int B_PRES_A = 2;
  localparam int B_PRES_B = 3;
  localparam int B_SUP    = 4;
  localparam int B_PROT_A = 5;
  localparam int B_PROT_B = 6;

  // synchronised input positions
  localparam int SY_ARST  = 0;
  localparam int SY_APWR  = 1;
  localparam int SY_BRST  = 2;
  localparam int SY_BPWR  = 3;
  localparam int SY_APRES = 4;
  localparam int SY_BPRES = 5;
  localparam int SY_AUX   = 6;
  localparam int SY_TEMP  = 7;
  localparam int SY_SFAIL = 8;
  localparam int SY_HOLD  = 9;
  localparam int SY_ALARM = 10;
  localparam int SY_W     = 11;

  // a set on the same edge as a clear wins
  function automatic logic latch_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic irq_active(logic [STAT_W-1:0] s, logic aux_en);
    return (|s[B_PROT_B:B_PRES_A]) | s[B_THERM] | (aux_en & s[B_AUX]);
  endfunction
endpackage

// File: rtl/fel_sync.sv
module fel_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fel_edge.sv
module fel_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] chg
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;

  assign chg = lvl ^ prev_q;
endmodule

// File: rtl/fel_read_pacer.sv
module fel_read_pacer #(
  parameter int GAP_CYCLES = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_stb,
  output logic rd_end,
  output logic rd_ready
);
  localparam int CW = $clog2(GAP_CYCLES + 1);

  logic          rd_q;
  logic [CW-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_stb;

  assign rd_end = rd_q & ~rd_stb;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              gap_cnt <= '0;
    else if (rd_end)         gap_cnt <= CW'(GAP_CYCLES);
    else if (gap_cnt != '0)  gap_cnt <= gap_cnt - 1'b1;

  assign rd_ready = (gap_cnt == '0);

  // R10: the end of a read always blocks the next one
  p_ready_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_end |=> !rd_ready);
endmodule

// File: rtl/fault_event_latch.sv
module fault_event_latch
  import fel_pkg::*;
#(
  parameter int GAP_CYCLES  = 250,
  parameter int SYNC_STAGES = 2,
  parameter bit AUX_IN_IRQ  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_rst_short,
  input  logic              a_pwr_short,
  input  logic              b_rst_short,
  input  logic              b_pwr_short,
  input  logic              a_present,
  input  logic              b_present,
  input  logic              aux_pin,
  input  logic              over_temp,
  input  logic              supply_fail,
  input  logic              ext_hold,
  input  logic              alarm_pulse,
  input  logic              rd_stb,
  output logic [STAT_W-1:0] rd_data,
  output logic              irq_n,
  output logic              drv_en,
  output logic              a_deact_req,
  output logic              b_deact_req,
  output logic              rd_ready
);
  localparam logic [LATCH_W-1:0] RST_VAL = LATCH_W'(1) << B_SUP;

  logic [SY_W-1:0]    raw, sy;
  logic [2:0]         chg;      // {aux, b presence, a presence}
  logic               rd_end;
  logic [LATCH_W-1:0] set_ev, clr_ev, stat_q;

  assign raw = {alarm_pulse, ext_hold, supply_fail, over_temp, aux_pin,
                b_present, a_present, b_pwr_short, b_rst_short,
                a_pwr_short, a_rst_short};

  fel_sync #(.W(SY_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(sy));

  fel_edge #(.W(3)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .lvl({sy[SY_AUX], sy[SY_BPRES], sy[SY_APRES]}), .chg(chg));

  fel_read_pacer #(.GAP_CYCLES(GAP_CYCLES)) u_pacer (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb),
    .rd_end(rd_end), .rd_ready(rd_ready));

  always_comb begin
    set_ev           = '0;
    set_ev[B_THERM]  = sy[SY_TEMP];
    set_ev[B_AUX]    = chg[2];
    set_ev[B_PRES_A] = chg[0];
    set_ev[B_PRES_B] = chg[1];
    set_ev[B_SUP]    = sy[SY_SFAIL] | sy[SY_HOLD];
    set_ev[B_PROT_A] = sy[SY_ARST] | sy[SY_APWR];
    set_ev[B_PROT_B] = sy[SY_BRST] | sy[SY_BPWR];
    clr_ev           = {LATCH_W{rd_end}};
    clr_ev[B_SUP]    = rd_end & ~sy[SY_ALARM];
  end

  for (genvar i = 0; i < LATCH_W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) stat_q[i] <= RST_VAL[i];
      else        stat_q[i] <= latch_next(stat_q[i], set_ev[i], clr_ev[i]);
  end

  assign rd_data     = {1'b0, stat_q};
  assign irq_n       = ~irq_active(rd_data, AUX_IN_IRQ);
  assign drv_en      = ~sy[SY_TEMP];
  assign a_deact_req = sy[SY_ARST];
  assign b_deact_req = sy[SY_BRST];

  // R2: a short still present at the end of a read keeps the bit
  p_prot_persist_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_end && (sy[SY_ARST] || sy[SY_APWR])) |=> stat_q[B_PROT_A]);
  // R4: a read with no fresh edge empties the presence bit
  p_pres_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_end && !chg[0]) |=> !stat_q[B_PRES_A]);
  // R5: only a read removes the auxiliary bit
  p_aux_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[B_AUX] && !rd_end) |=> stat_q[B_AUX]);
  // R6: a read during the alarm pulse keeps the supervisor bit
  p_sup_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_end && sy[SY_ALARM] && stat_q[B_SUP]) |=> stat_q[B_SUP]);
  // R9: a fresh edge coinciding with a clear survives
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_end && chg[1]) |=> stat_q[B_PRES_B]);
endmodule

// File: tb/fault_event_latch_tb.sv
module fault_event_latch_tb;
  localparam int GAP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_rst_short = 0, a_pwr_short = 0, b_rst_short = 0, b_pwr_short = 0;
  logic a_present = 0, b_present = 0, aux_pin = 0, over_temp = 0;
  logic supply_fail = 0, ext_hold = 0, alarm_pulse = 0, rd_stb = 0;
  logic [7:0] rd_data, rd_data_x;
  logic irq_n, drv_en, a_deact_req, b_deact_req, rd_ready;
  logic irq_n_x, drv_en_x, a_deact_x, b_deact_x, rd_ready_x;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fault_event_latch #(.GAP_CYCLES(GAP), .AUX_IN_IRQ(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .a_rst_short(a_rst_short), .a_pwr_short(a_pwr_short),
    .b_rst_short(b_rst_short), .b_pwr_short(b_pwr_short), .a_present(a_present),
    .b_present(b_present), .aux_pin(aux_pin), .over_temp(over_temp),
    .supply_fail(supply_fail), .ext_hold(ext_hold), .alarm_pulse(alarm_pulse),
    .rd_stb(rd_stb), .rd_data(rd_data), .irq_n(irq_n), .drv_en(drv_en),
    .a_deact_req(a_deact_req), .b_deact_req(b_deact_req), .rd_ready(rd_ready));

  fault_event_latch #(.GAP_CYCLES(GAP), .AUX_IN_IRQ(1'b1)) u_dut_aux (
    .clk(clk), .rst_n(rst_n), .a_rst_short(a_rst_short), .a_pwr_short(a_pwr_short),
    .b_rst_short(b_rst_short), .b_pwr_short(b_pwr_short), .a_present(a_present),
    .b_present(b_present), .aux_pin(aux_pin), .over_temp(over_temp),
    .supply_fail(supply_fail), .ext_hold(ext_hold), .alarm_pulse(alarm_pulse),
    .rd_stb(rd_stb), .rd_data(rd_data_x), .irq_n(irq_n_x), .drv_en(drv_en_x),
    .a_deact_req(a_deact_x), .b_deact_req(b_deact_x), .rd_ready(rd_ready_x));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // strobe for one cycle; returns at the negedge after the clearing edge
  task automatic do_read();
    @(negedge clk) rd_stb = 1'b1;
    @(negedge clk) rd_stb = 1'b0;
    @(negedge clk);
  endtask

  // expected interrupt, restated from the requirement text
  function automatic logic exp_irq_n(logic [7:0] s, bit aux_counts);
    logic [7:0] mask;
    mask = aux_counts ? 8'b0111_1111 : 8'b0111_1101;
    return (s & mask) == 8'h00;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 reset byte", rd_data, 8'h10);
    check("R1 reset irq", {7'd0, irq_n}, 8'd0);
    check("R1 reset ready", {7'd0, rd_ready}, 8'd1);
    check("R1 reset drv_en", {7'd0, drv_en}, 8'd1);
    check("R1 reset deact", {6'd0, a_deact_req, b_deact_req}, 8'd0);

    do_read();
    check("R6 clear outside alarm", rd_data, 8'h00);
    check("R7 irq idle", {7'd0, irq_n}, 8'd1);
    // R10 gap
    for (int k = 0; k < GAP; k++) begin
      check("R10 ready low", {7'd0, rd_ready}, 8'd0);
      tick(1);
    end
    check("R10 ready back", {7'd0, rd_ready}, 8'd1);

    // R2 / R8 sweep over every short combination
    for (int c = 1; c < 16; c++) begin
      logic [7:0] e;
      {b_pwr_short, b_rst_short, a_pwr_short, a_rst_short} = 4'(c);
      tick(4);
      e = {1'b0, (c[2] | c[3]), (c[0] | c[1]), 5'b0};
      check("R2 short sets", rd_data, e);
      check("R8 deact", {6'd0, a_deact_req, b_deact_req}, {6'd0, c[0], c[2]});
      check("R7 irq shorts", {7'd0, irq_n}, {7'd0, exp_irq_n(e, 0)});
      do_read();
      check("R2 persist over read", rd_data, e);
      {b_pwr_short, b_rst_short, a_pwr_short, a_rst_short} = 4'd0;
      tick(4);
      check("R2 kept after release", rd_data, e);
      do_read();
      check("R2 clear after release", rd_data, 8'h00);
      tick(GAP);
    end

    // R3 thermal
    over_temp = 1'b1;
    tick(4);
    check("R3 thermal sets", rd_data, 8'h01);
    check("R3 drv_en off", {7'd0, drv_en}, 8'd0);
    check("R7 irq thermal", {7'd0, irq_n}, 8'd0);
    do_read();
    check("R3 persist over read", rd_data, 8'h01);
    over_temp = 1'b0;
    tick(4);
    check("R3 drv_en back", {7'd0, drv_en}, 8'd1);
    do_read();
    check("R3 clear after release", rd_data, 8'h00);
    tick(GAP);

    // R4 / R5 / R7 sweep over edge subsets, both edge directions
    for (int pass = 0; pass < 2; pass++) begin
      for (int m = 1; m < 8; m++) begin
        logic [7:0] e;
        if (m[0]) a_present = ~a_present;
        if (m[1]) b_present = ~b_present;
        if (m[2]) aux_pin = ~aux_pin;
        tick(4);
        e = {4'b0, m[1], m[0], m[2], 1'b0};
        check("R4 presence edge", rd_data, e);
        check("R7 irq aux off", {7'd0, irq_n}, {7'd0, exp_irq_n(e, 0)});
        check("R7 irq aux on", {7'd0, irq_n_x}, {7'd0, exp_irq_n(e, 1)});
        do_read();
        check("R4 read clears", rd_data, 8'h00);
        tick(GAP);
      end
    end

    // R5 sticky through a return edge
    aux_pin = ~aux_pin;
    tick(4);
    aux_pin = ~aux_pin;
    tick(4);
    check("R5 aux sticky", rd_data, 8'h02);
    do_read();
    check("R5 read clears aux", rd_data, 8'h00);
    tick(GAP);

    // R6 supervisor
    supply_fail = 1'b1;
    tick(4);
    supply_fail = 1'b0;
    tick(4);
    check("R6 supply fail sets", rd_data, 8'h10);
    alarm_pulse = 1'b1;
    tick(4);
    do_read();
    check("R6 read in alarm keeps", rd_data, 8'h10);
    alarm_pulse = 1'b0;
    tick(4);
    do_read();
    check("R6 read after alarm clears", rd_data, 8'h00);
    tick(GAP);
    ext_hold = 1'b1;
    tick(4);
    ext_hold = 1'b0;
    tick(4);
    check("R6 hold sets", rd_data, 8'h10);
    do_read();
    check("R6 hold cleared", rd_data, 8'h00);
    tick(GAP);

    // R11 latency of status and of drv_en
    b_present = ~b_present;
    over_temp = 1'b1;
    @(negedge clk);
    check("R11 drv_en after 1 edge", {7'd0, drv_en}, 8'd1);
    @(negedge clk);
    check("R11 status after 2 edges", rd_data, 8'h00);
    check("R11 drv_en after 2 edges", {7'd0, drv_en}, 8'd0);
    @(negedge clk);
    check("R11 status after 3 edges", rd_data, 8'h09);
    over_temp = 1'b0;
    tick(4);
    do_read();
    check("R11 cleanup", rd_data, 8'h00);
    tick(GAP);

    // R9 edge meets the clearing edge
    a_present = ~a_present;
    @(negedge clk) rd_stb = 1'b1;
    @(negedge clk) rd_stb = 1'b0;
    @(negedge clk);
    check("R9 set wins over clear", rd_data, 8'h04);
    tick(GAP);
    do_read();
    check("R9 later read clears", rd_data, 8'h00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule